// File: doc/BRIEF.md
# Bit-Sliced Shift-and-Add Dot-Product Accumulator

This block rebuilds a signed multi-bit dot product from the digitised partial sums of an analog multiply array. Each weight is held as several cells of a few bits each. The array therefore delivers one converter word per weight cell column. It does this twice, once for an array holding the positive part of the weights and once for an array holding the negative part. The input vector is fed to the array a few bits at a time. The block must merge the per-cell column words and then the per-input-slice results into one number.

In each accepted cycle, the block shifts each cell column word by its cell significance and sums the shifted words into a partial result. It then folds that partial result into a running sum. Input slices arrive most significant first, so the running sum is shifted left by the input slice width before each new partial result is added. A start pulse opens a job. After the last slice, the block presents the positive sum minus the negative sum and raises a one-cycle completion flag.

Top module: `slice_dot_accum`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `result` are all zero.
- R2: Cell column m of an array is the field `cols[m*ADC_W +: ADC_W]`, read as unsigned, with m = 0 the least significant cell. Its word is weighted by 2^(CELL_BITS*m) before the words of that array are summed into the cycle's partial result.
- R3: The first accepted slice is the most significant. On every accepted slice, the running sum of each array becomes the previous running sum times 2^SLICE_BITS plus the new partial result.
- R4: `done` goes high for exactly one cycle, in the cycle right after the clock edge that accepts the NUM_SLICES-th slice of a job. `busy` falls in that same cycle. `done` is never high in any other cycle.
- R5: On completion, `result` is the two's-complement value of the positive-array sum minus the negative-array sum, ACC_W bits wide. It is exact even when every column word is at full scale in only one of the arrays.
- R6: `result` holds its value in every cycle except the one in which `done` is high.
- R7: A `slice_valid` pulse while `busy` is low is ignored. It does not change `result`, does not raise `done`, and does not count towards the next job.
- R8: A `start` pulse clears both running sums and the slice count and sets `busy`, even in the middle of a job. A `slice_valid` in the same cycle as `start` is ignored.
- R9: Slices may be separated by any number of idle cycles. Only cycles with `slice_valid` high while `busy` is high advance the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new job, aborting any job in progress |
| slice_valid | input | 1 | Single-cycle strobe that marks the column words of one input slice |
| pos_cols | input | NUM_CELLS*ADC_W | Column words of the positive-weight array, cell 0 in the low field |
| neg_cols | input | NUM_CELLS*ADC_W | Column words of the negative-weight array, cell 0 in the low field |
| busy | output | 1 | High from start until the last slice of the job is accepted |
| done | output | 1 | One-cycle completion flag |
| result | output | ACC_W | Signed difference of the positive and negative sums |

## Verification
Several internal faults show up only at the end of a job. A wrong shift amount, a wrong cell weighting or a mis-ordered accumulation stays hidden until `done` rises. At that point it appears as a wrong `result` value, so every job is checked against a model value derived from the slice words. A slice counter that is off by one, or that counts strobes while idle, moves `done` one or more cycles away from the expected cycle. The bench checks the `done` level after every strobe. A running sum that a new start fails to clear shows up as a wrong value at the end of the following job.

// File: rtl/sda_pkg.sv
package sda_pkg;
   // Unsigned width of one cycle's weighted cell sum.
   function automatic int part_width(input int adc_w, input int cell_bits, input int num_cells);
      return adc_w + cell_bits * num_cells;
   endfunction

   // Signed width of the final difference.
   function automatic int result_width(input int adc_w, input int cell_bits, input int num_cells,
                                       input int slice_bits, input int num_slices);
      return part_width(adc_w, cell_bits, num_cells) + slice_bits * num_slices + 1;
   endfunction
endpackage

// File: rtl/sda_weigher.sv
module sda_weigher #(
   parameter int ADC_W     = 6,
   parameter int CELL_BITS = 1,
   parameter int NUM_CELLS = 4,
   parameter int PART_W    = 10
) (
   input  logic [NUM_CELLS*ADC_W-1:0] cols,
   output logic [PART_W-1:0]          partial
);
   logic [NUM_CELLS-1:0][PART_W-1:0] term;

   for (genvar m = 0; m < NUM_CELLS; m++) begin : g_cell
      assign term[m] = PART_W'(cols[m*ADC_W +: ADC_W]) << (CELL_BITS * m);
   end

   always_comb begin
      partial = '0;
      for (int m = 0; m < NUM_CELLS; m++) begin
         partial = partial + term[m];
      end
   end
endmodule

// File: rtl/sda_shift_acc.sv
module sda_shift_acc #(
   parameter int PART_W     = 10,
   parameter int SLICE_BITS = 1,
   parameter int SUM_W      = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [PART_W-1:0] partial,
   output logic [SUM_W-1:0]  sum_next
);
   logic [SUM_W-1:0] sum_q;

   assign sum_next = (sum_q << SLICE_BITS) + SUM_W'(partial);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (clear) sum_q <= '0;
      else if (take)  sum_q <= sum_next;
   end
endmodule

// File: rtl/sda_sequencer.sv
module sda_sequencer #(
   parameter int NUM_SLICES = 8,
   parameter int CNT_W      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic slice_valid,
   output logic take,
   output logic last_take,
   output logic busy,
   output logic done
);
   logic [CNT_W-1:0] cnt_q;

   assign take      = slice_valid && busy && !start;
   assign last_take = take && (cnt_q == CNT_W'(NUM_SLICES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= last_take;
         if (start) begin
            cnt_q <= '0;
            busy  <= 1'b1;
         end else if (last_take) begin
            cnt_q <= '0;
            busy  <= 1'b0;
         end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/slice_dot_accum.sv
module slice_dot_accum #(
   parameter int ADC_W      = 6,
   parameter int CELL_BITS  = 1,
   parameter int NUM_CELLS  = 4,
   parameter int SLICE_BITS = 1,
   parameter int NUM_SLICES = 8,
   localparam int PART_W    = sda_pkg::part_width(ADC_W, CELL_BITS, NUM_CELLS),
   localparam int ACC_W     = sda_pkg::result_width(ADC_W, CELL_BITS, NUM_CELLS, SLICE_BITS, NUM_SLICES),
   localparam int SUM_W     = ACC_W - 1,
   localparam int COL_W     = NUM_CELLS * ADC_W,
   localparam int CNT_W     = $clog2(NUM_SLICES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    slice_valid,
   input  logic [COL_W-1:0]        pos_cols,
   input  logic [COL_W-1:0]        neg_cols,
   output logic                    busy,
   output logic                    done,
   output logic signed [ACC_W-1:0] result
);
   if (ADC_W < 1)      begin : g_bad_adc   $error("ADC_W must be at least 1");      end
   if (CELL_BITS < 1)  begin : g_bad_cell  $error("CELL_BITS must be at least 1");  end
   if (NUM_CELLS < 1)  begin : g_bad_cells $error("NUM_CELLS must be at least 1");  end
   if (SLICE_BITS < 1) begin : g_bad_slice $error("SLICE_BITS must be at least 1"); end
   if (NUM_SLICES < 1) begin : g_bad_nsl   $error("NUM_SLICES must be at least 1"); end
   if (ACC_W > 62)     begin : g_bad_acc   $error("ACC_W exceeds 62 bits");         end

   logic take, last_take;
   logic [1:0][COL_W-1:0]  cols_arr;
   logic [1:0][PART_W-1:0] part_arr;
   logic [1:0][SUM_W-1:0]  next_arr;

   assign cols_arr[0] = pos_cols;
   assign cols_arr[1] = neg_cols;

   sda_sequencer #(.NUM_SLICES(NUM_SLICES), .CNT_W(CNT_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .slice_valid(slice_valid),
      .take(take), .last_take(last_take), .busy(busy), .done(done)
   );

   // index 0: positive-weight array, index 1: negative-weight array
   for (genvar a = 0; a < 2; a++) begin : g_array
      sda_weigher #(.ADC_W(ADC_W), .CELL_BITS(CELL_BITS), .NUM_CELLS(NUM_CELLS), .PART_W(PART_W)) i_wgt (
         .cols(cols_arr[a]), .partial(part_arr[a])
      );
      sda_shift_acc #(.PART_W(PART_W), .SLICE_BITS(SLICE_BITS), .SUM_W(SUM_W)) i_acc (
         .clk(clk), .rst_n(rst_n), .clear(start), .take(take),
         .partial(part_arr[a]), .sum_next(next_arr[a])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         result <= '0;
      else if (last_take) result <= $signed({1'b0, next_arr[0]}) - $signed({1'b0, next_arr[1]});
   end
endmodule

// File: rtl/sda_checker.sv
module sda_checker #(
   parameter int ACC_W = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             slice_valid,
   input logic             busy,
   input logic             done,
   input logic [ACC_W-1:0] result
);
   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_result_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || $stable(result)));

   assert_idle_strobe_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start && slice_valid) |=> (!done && !busy));

   assert_start_opens_job_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !done));

   always_comb begin
      if (!rst_n) begin
         assert_reset_state_R1: assert (!busy && !done && result == '0);
      end
   end
endmodule

bind slice_dot_accum sda_checker #(.ACC_W(ACC_W)) i_sda_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .slice_valid(slice_valid),
   .busy(busy), .done(done), .result(result)
);

// File: tb/test_slice_dot_accum.sv
module test_slice_dot_accum;
   localparam int A  = 6;
   localparam int C  = 1;
   localparam int M  = 4;
   localparam int X  = 1;
   localparam int NS = 8;
   localparam int W  = A + C * M + X * NS + 1;
   localparam int CW = M * A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic slice_valid = 1'b0;
   logic [CW-1:0] pos_cols = '0;
   logic [CW-1:0] neg_cols = '0;
   logic busy, done;
   logic signed [W-1:0] result;

   int checks = 0;
   int fails  = 0;
   logic [CW-1:0] pv [NS];
   logic [CW-1:0] nv [NS];

   always #10 clk = ~clk;

   slice_dot_accum i_slice_dot_accum (
      .clk(clk), .rst_n(rst_n), .start(start), .slice_valid(slice_valid),
      .pos_cols(pos_cols), .neg_cols(neg_cols),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint wsum(input logic [CW-1:0] v);
      longint s = 0;
      for (int m = 0; m < M; m++) s += longint'(v[m*A +: A]) << (C * m);
      return s;
   endfunction

   function automatic longint model();
      longint sp = 0, sn = 0;
      for (int n = 0; n < NS; n++) begin
         sp = (sp << X) + wsum(pv[n]);
         sn = (sn << X) + wsum(nv[n]);
      end
      return sp - sn;
   endfunction

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !done, "R8 start sets busy", longint'(busy), 1);
   endtask

   task automatic feed(input int max_gap, input string tag);
      longint exp = model();
      longint held;
      for (int n = 0; n < NS; n++) begin
         int gap = (max_gap > 0) ? int'($urandom_range(0, max_gap)) : 0;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(!done, "R9 no done during gap", longint'(done), 0);
         end
         slice_valid = 1'b1;
         pos_cols = pv[n];
         neg_cols = nv[n];
         @(negedge clk);
         slice_valid = 1'b0;
         pos_cols = '1;
         neg_cols = '1;
         if (n < NS - 1) chk(!done, "R4 no early done", longint'(done), 0);
      end
      chk(done == 1'b1, "R4 done after last slice", longint'(done), 1);
      chk(!busy, "R4 busy falls with done", longint'(busy), 0);
      chk(longint'(result) == exp, tag, longint'(result), exp);
      held = longint'(result);
      @(negedge clk);
      chk(!done, "R4 done lasts one cycle", longint'(done), 0);
      chk(longint'(result) == held, "R6 result holds", longint'(result), held);
   endtask

   task automatic fill_random();
      for (int n = 0; n < NS; n++) begin
         pv[n] = CW'($urandom);
         nv[n] = CW'($urandom);
      end
   endtask

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      chk(!busy && !done && result == '0, "R1 reset state", longint'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && result == '0, "R1 after release", longint'(result), 0);

      // R2: single cell weighting, placed in the last (least significant) slice
      for (int m = 0; m < M; m++) begin
         for (int n = 0; n < NS; n++) begin pv[n] = '0; nv[n] = '0; end
         pv[NS-1][m*A +: A] = A'(1);
         pulse_start();
         feed(0, "R2 cell significance");
      end

      // R3: first slice carries the top significance
      for (int n = 0; n < NS; n++) begin pv[n] = '0; nv[n] = '0; end
      pv[0][A-1:0] = A'(1);
      pulse_start();
      feed(0, "R3 msb first");

      // R5: extremes
      for (int n = 0; n < NS; n++) begin pv[n] = '1; nv[n] = '0; end
      pulse_start();
      feed(0, "R5 max positive");
      for (int n = 0; n < NS; n++) begin pv[n] = '0; nv[n] = '1; end
      pulse_start();
      feed(0, "R5 max negative");
      for (int n = 0; n < NS; n++) begin pv[n] = '0; nv[n] = '0; end
      pulse_start();
      feed(0, "R5 zero");

      // R7: idle strobes ignored, and not counted towards the next job
      begin
         longint held = longint'(result);
         for (int k = 0; k < 3; k++) begin
            slice_valid = 1'b1;
            pos_cols = CW'($urandom);
            neg_cols = CW'($urandom);
            @(negedge clk);
            chk(!done && !busy && longint'(result) == held, "R7 idle strobe ignored",
                longint'(result), held);
         end
         slice_valid = 1'b0;
      end
      fill_random();
      pulse_start();
      feed(0, "R7 count unaffected");

      // R8: abort mid-job, with a strobe alongside the new start
      fill_random();
      pulse_start();
      for (int k = 0; k < 3; k++) begin
         slice_valid = 1'b1;
         pos_cols = '1;
         neg_cols = CW'($urandom);
         @(negedge clk);
      end
      start = 1'b1;
      slice_valid = 1'b1;
      pos_cols = '1;
      @(negedge clk);
      start = 1'b0;
      slice_valid = 1'b0;
      chk(busy && !done, "R8 restart busy", longint'(busy), 1);
      feed(0, "R8 abort clears sums");

      // R3/R5/R9: random jobs with gaps
      for (int j = 0; j < 20; j++) begin
         fill_random();
         pulse_start();
         feed(j % 3, "R9 random job with gaps");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule